// File: doc/BRIEF.md
# Streaming Mean and Covariance Unit

This unit reduces a stored data set of `n` vectors, each with `m` signed Q8.8 elements, to its per-dimension mean and its sample covariance matrix. The samples live in a local dual-read memory laid out vector by vector, so element `i` of vector `k` sits at word `k*m + i`. After a `start` pulse the unit latches `m` and `n`. It then streams the memory once per result, accumulating one sample (or one product of two samples) per clock cycle in a 40-bit accumulator.

The unit first makes one pass per dimension to form the column sums. Each sum goes through a shared restoring divider to give the mean. It then makes one pass per entry of the diagonal and upper triangle of the covariance matrix. Each pass multiplies the two deviations from the mean and accumulates the product, and the final sum is divided by `n-1`. During each diagonal pass, every deviation from the mean is also written out so that later stages can reuse it. All results leave through one write strobe that carries a result kind, an address and a 40-bit value. The divider holds the read stream still while it runs.

Top module: `meancov_engine`

## Requirements
- R1: For each dimension i in 0..m-1, one write appears with kind 0 (mean), address i and value trunc(sum over k of x_ki / n), sign-extended to 40 bits. The means are written in ascending order of i, before any other result.
- R2: After the means, one write appears with kind 2 (covariance) for each pair i ≤ j, in row-major order (i outer, j inner). Its address is the running index 0..m(m+1)/2-1. Its value is trunc(sum over k of (x_ki − mean_i)(x_kj − mean_j) / (n−1)), using the truncated means of R1.
- R3: Immediately before the covariance write for pair (i,i), n writes appear with kind 1 (deviation). They carry address k*m+i and value x_ki − mean_i, sign-extended, in ascending order of k.
- R4: Each accumulation pass asserts `rd_en` for exactly n consecutive cycles. Port A reads word k*m+i and port B reads word k*m+j. Read data is taken one cycle after the address.
- R5: `wr_kind` is never 3 while `wr_valid` is high.
- R6: A `start` pulse while `busy` is high is ignored, and the run in progress completes with its own configuration.
- R7: `done` is a one-cycle pulse in the cycle of the final covariance write, with `busy` already low.
- R8: After reset, `busy`, `done`, `rd_en` and `wr_valid` are low.
- R9: Negative sums are divided with truncation toward zero.
- R10: While the divider runs, `rd_en` stays low. A run therefore shows exactly m + m(m+1)/2 separate read bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run with the configuration on the cfg inputs |
| cfg_dims | input | DIM_W | Number of dimensions m (1..DIM_MAX) |
| cfg_count | input | CNT_W | Number of vectors n (2..CNT_MAX) |
| rd_en | output | 1 | Read request to the sample memory |
| rd_addr_a | output | ADDR_W | Word address for read port A (element i) |
| rd_addr_b | output | ADDR_W | Word address for read port B (element j) |
| rd_data_a | input | DATA_W | Port A sample, one cycle after the address |
| rd_data_b | input | DATA_W | Port B sample, one cycle after the address |
| wr_valid | output | 1 | Result write strobe |
| wr_kind | output | 2 | 0 mean, 1 deviation, 2 covariance |
| wr_addr | output | ADDR_W | Result address |
| wr_data | output | ACC_W | Signed result value |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run-complete pulse |

## Verification
The assertions take for granted a legal configuration at `start`: m at least 1 and n at least 2, so the covariance divisor is never zero. They also assume `rst_n` is held low for the first edges of the run. The stimulus only ever loads configurations in that range, including the minimum pair m=1, n=2 and the maximum m=8, n=64. It keeps its sample values within Q8.8, which keeps every 40-bit sum free of overflow. Its only illegal-timing stimulus is a `start` raised in mid-run, and that case carries a configuration different from the run in progress.

// File: rtl/meancov_pkg.sv
// Shared types for the mean/covariance unit.
// Assumes: result kind codes are fixed, because downstream logic decodes them.
package meancov_pkg;

    typedef enum logic [1:0] {
        KIND_MEAN = 2'd0,
        KIND_DEV  = 2'd1,
        KIND_COV  = 2'd2
    } res_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DIVL,
        ST_DIV
    } seq_state_t;

endpackage

// File: rtl/meancov_divider.sv
// Restoring divider of a signed dividend by an unsigned divisor.
// It takes NUM_W cycles after start. The quotient is truncated toward zero and
// is valid in the cycle done is high.
// Assumes: den is nonzero and start is only raised while busy is low.
module meancov_divider #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [NUM_W-1:0] num,
    input  logic [DEN_W-1:0]        den,
    output logic                    busy,
    output logic                    done,
    output logic signed [NUM_W-1:0] quo
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0]  q_sh;
    logic [DEN_W:0]    rem;
    logic [DEN_W:0]    shifted;
    logic [STEP_W-1:0] steps;
    logic              neg;
    logic [DEN_W-1:0]  den_q;

    // Partial remainder with the next dividend bit shifted in.
    always_comb begin
        shifted = {rem[DEN_W-1:0], q_sh[NUM_W-1]};
    end

    assign quo = neg ? -$signed(q_sh) : $signed(q_sh);

    // One restoring step per cycle; the sign is restored at the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_sh  <= '0;
            rem   <= '0;
            steps <= '0;
            neg   <= 1'b0;
            den_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                steps <= STEP_W'(NUM_W);
                neg   <= num[NUM_W-1];
                q_sh  <= num[NUM_W-1] ? NUM_W'(-num) : NUM_W'(num);
                rem   <= '0;
                den_q <= den;
            end else if (busy) begin
                if (shifted >= {1'b0, den_q}) begin
                    rem  <= shifted - {1'b0, den_q};
                    q_sh <= {q_sh[NUM_W-2:0], 1'b1};
                end else begin
                    rem  <= shifted;
                    q_sh <= {q_sh[NUM_W-2:0], 1'b0};
                end
                steps <= steps - STEP_W'(1);
                if (steps == STEP_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/meancov_accum.sv
// Accumulator: an adder whose registered sum feeds back to one of its inputs.
// Assumes: clear and add_en are never needed together; clear wins if they are.
module meancov_accum #(
    parameter int ACC_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    add_en,
    input  logic signed [ACC_W-1:0] term,
    output logic signed [ACC_W-1:0] acc
);
    // Clear at each new result, otherwise add one term per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= acc + term;
        end
    end

endmodule

// File: rtl/meancov_seq.sv
// Pass sequencer. It issues one read per cycle for n cycles per result and
// waits for the divider between passes. It steps through the means and then
// the covariance pairs i <= j in row-major order.
// Assumes: cfg_dims >= 1 and cfg_count >= 2 when start is seen.
module meancov_seq
    import meancov_pkg::*;
#(
    parameter int DIM_W  = 4,
    parameter int CNT_W  = 7,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_dims,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              div_done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    output logic              phase_cov,
    output logic [DIM_W-1:0]  idx_i,
    output logic [DIM_W-1:0]  idx_j,
    output logic [ADDR_W-1:0] cov_idx,
    output logic [CNT_W-1:0]  n_cfg,
    output logic              div_start,
    output logic              acc_clear,
    output logic              busy,
    output logic              done
);
    seq_state_t        state;
    logic [DIM_W-1:0]  m_q;
    logic [CNT_W-1:0]  k;
    logic [ADDR_W-1:0] base;
    logic              last_k, last_i, last_j;

    assign rd_en     = (state == ST_RUN);
    assign rd_addr_a = base + ADDR_W'(idx_i);
    assign rd_addr_b = base + ADDR_W'(idx_j);
    assign div_start = (state == ST_DIVL);
    assign acc_clear = (state == ST_IDLE) || div_done;
    assign busy      = (state != ST_IDLE);
    assign last_k    = (k == n_cfg - CNT_W'(1));
    assign last_i    = (idx_i == m_q - DIM_W'(1));
    assign last_j    = (idx_j == m_q - DIM_W'(1));

    // State, pass indices and the running row base k*m.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            m_q       <= '0;
            n_cfg     <= '0;
            k         <= '0;
            base      <= '0;
            phase_cov <= 1'b0;
            idx_i     <= '0;
            idx_j     <= '0;
            cov_idx   <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    m_q       <= cfg_dims;
                    n_cfg     <= cfg_count;
                    k         <= '0;
                    base      <= '0;
                    phase_cov <= 1'b0;
                    idx_i     <= '0;
                    idx_j     <= '0;
                    cov_idx   <= '0;
                    state     <= ST_RUN;
                end
                ST_RUN: begin
                    if (last_k) begin
                        k     <= '0;
                        base  <= '0;
                        state <= ST_DRAIN;
                    end else begin
                        k    <= k + CNT_W'(1);
                        base <= base + ADDR_W'(m_q);
                    end
                end
                ST_DRAIN: state <= ST_DIVL;
                ST_DIVL:  state <= ST_DIV;
                ST_DIV: if (div_done) begin
                    state <= ST_RUN;
                    if (!phase_cov) begin
                        if (last_i) begin
                            phase_cov <= 1'b1;
                            idx_i     <= '0;
                            idx_j     <= '0;
                        end else begin
                            idx_i <= idx_i + DIM_W'(1);
                            idx_j <= idx_i + DIM_W'(1);
                        end
                    end else begin
                        cov_idx <= cov_idx + ADDR_W'(1);
                        if (last_j) begin
                            if (last_i) begin
                                state <= ST_IDLE;
                                done  <= 1'b1;
                            end else begin
                                idx_i <= idx_i + DIM_W'(1);
                                idx_j <= idx_i + DIM_W'(1);
                            end
                        end else begin
                            idx_j <= idx_j + DIM_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/meancov_engine.sv
// Streaming mean and covariance unit, top level.
// It is built from a sequencer, a one-stage read pipeline, deviation and
// product logic, an accumulator and a shared divider. It also holds the
// result write port.
// Assumes: the sample memory returns data one cycle after rd_en/address,
// and samples are signed Q8.8.
module meancov_engine
    import meancov_pkg::*;
#(
    parameter int DIM_MAX = 8,
    parameter int CNT_MAX = 64,
    parameter int DATA_W  = 16,
    parameter int ACC_W   = 40,
    parameter int DIM_W   = $clog2(DIM_MAX + 1),
    parameter int CNT_W   = $clog2(CNT_MAX + 1),
    parameter int ADDR_W  = $clog2(DIM_MAX * CNT_MAX + DIM_MAX * DIM_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_dims,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    input  logic [DATA_W-1:0] rd_data_a,
    input  logic [DATA_W-1:0] rd_data_b,
    output logic              wr_valid,
    output logic [1:0]        wr_kind,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ACC_W-1:0]  wr_data,
    output logic              busy,
    output logic              done
);
    localparam int DEV_W  = DATA_W + 1;
    localparam int PROD_W = 2 * DEV_W;
    localparam int RF_N   = 1 << DIM_W;

    logic              phase_cov, div_start, acc_clear, div_done, div_busy;
    logic [DIM_W-1:0]  idx_i, idx_j;
    logic [ADDR_W-1:0] cov_idx;
    logic [CNT_W-1:0]  n_cfg;

    logic              pend_v, pend_diag, pend_cov;
    logic [ADDR_W-1:0] pend_addr;
    logic [DIM_W-1:0]  pend_i, pend_j;

    logic [DATA_W-1:0]        mean_rf [RF_N];
    logic signed [DEV_W-1:0]  dev_a, dev_b;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  term, acc, quo;
    logic [CNT_W-1:0]         den;

    meancov_seq #(.DIM_W(DIM_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_dims(cfg_dims), .cfg_count(cfg_count), .div_done(div_done),
        .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .phase_cov(phase_cov), .idx_i(idx_i), .idx_j(idx_j),
        .cov_idx(cov_idx), .n_cfg(n_cfg), .div_start(div_start),
        .acc_clear(acc_clear), .busy(busy), .done(done)
    );

    // Tag each returning sample with the pass it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_diag <= 1'b0;
            pend_cov  <= 1'b0;
            pend_addr <= '0;
            pend_i    <= '0;
            pend_j    <= '0;
        end else begin
            pend_v    <= rd_en;
            pend_diag <= phase_cov && (idx_i == idx_j);
            pend_cov  <= phase_cov;
            pend_addr <= rd_addr_a;
            pend_i    <= idx_i;
            pend_j    <= idx_j;
        end
    end

    // Deviation from the stored mean and the product of the two deviations.
    always_comb begin
        dev_a = $signed({rd_data_a[DATA_W-1], rd_data_a})
              - $signed({mean_rf[pend_i][DATA_W-1], mean_rf[pend_i]});
        dev_b = $signed({rd_data_b[DATA_W-1], rd_data_b})
              - $signed({mean_rf[pend_j][DATA_W-1], mean_rf[pend_j]});
        prod  = dev_a * dev_b;
        if (pend_cov) begin
            term = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        end else begin
            term = {{(ACC_W-DATA_W){rd_data_a[DATA_W-1]}}, rd_data_a};
        end
        den = phase_cov ? (n_cfg - CNT_W'(1)) : n_cfg;
    end

    meancov_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(acc_clear),
        .add_en(pend_v), .term(term), .acc(acc)
    );

    meancov_divider #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(acc),
        .den(den), .busy(div_busy), .done(div_done), .quo(quo)
    );

    // Keep each finished mean for the covariance passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < RF_N; e++) begin
                mean_rf[e] <= '0;
            end
        end else if (div_done && !phase_cov) begin
            mean_rf[idx_i] <= quo[DATA_W-1:0];
        end
    end

    // Result port: divider results take the slot, deviations fill the passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_kind  <= KIND_MEAN;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (div_done) begin
                wr_valid <= 1'b1;
                wr_kind  <= phase_cov ? KIND_COV : KIND_MEAN;
                wr_addr  <= phase_cov ? cov_idx : ADDR_W'(idx_i);
                wr_data  <= quo;
            end else if (pend_v && pend_diag) begin
                wr_valid <= 1'b1;
                wr_kind  <= KIND_DEV;
                wr_addr  <= pend_addr;
                wr_data  <= {{(ACC_W-DEV_W){dev_a[DEV_W-1]}}, dev_a};
            end
        end
    end

endmodule

// File: rtl/meancov_checker.sv
// Protocol checker for meancov_engine, attached with bind.
// Assumes: rst_n is low on the first clock edges.
module meancov_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       rd_en,
    input logic       wr_valid,
    input logic [1:0] wr_kind,
    input logic       div_busy
);
    p_reset_idle_r8: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !rd_en && !wr_valid));

    p_kind_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_kind != 2'd3));

    p_no_read_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !rd_en);

    p_read_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind meancov_engine meancov_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_en(rd_en), .wr_valid(wr_valid), .wr_kind(wr_kind), .div_busy(div_busy)
);

// File: tb/meancov_engine_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected writes, the monitor pops them.
module meancov_engine_tb_top;
    localparam int DIM_MAX = 8;
    localparam int CNT_MAX = 64;
    localparam int DATA_W  = 16;
    localparam int ACC_W   = 40;
    localparam int DIM_W   = $clog2(DIM_MAX + 1);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int ADDR_W  = $clog2(DIM_MAX * CNT_MAX + DIM_MAX * DIM_MAX);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DIM_W-1:0]  cfg_dims = '0;
    logic [CNT_W-1:0]  cfg_count = '0;
    logic              rd_en, wr_valid, busy, done;
    logic [ADDR_W-1:0] rd_addr_a, rd_addr_b, wr_addr;
    logic [DATA_W-1:0] rd_data_a, rd_data_b;
    logic [1:0]        wr_kind;
    logic [ACC_W-1:0]  wr_data;

    logic [DATA_W-1:0] mem [DIM_MAX*CNT_MAX];

    int     checks = 0;
    int     errors = 0;
    int     q_kind[$];
    int     q_addr[$];
    longint q_data[$];
    string  q_tag[$];
    int     run_len = 0;
    int     bursts = 0;
    int     cur_n = 0;

    always #5 clk = ~clk;

    meancov_engine #(.DIM_MAX(DIM_MAX), .CNT_MAX(CNT_MAX), .DATA_W(DATA_W), .ACC_W(ACC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_dims(cfg_dims), .cfg_count(cfg_count),
        .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    // Sample memory with one cycle of read latency on both ports.
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data_a <= mem[rd_addr_a];
            rd_data_b <= mem[rd_addr_b];
        end
    end

    // Monitor: compare each write with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            checks++;
            if (wr_kind == 2'd3) begin
                errors++;
                $display("FAIL R5 kind actual=%0d expected 0..2", wr_kind);
            end
            if (q_kind.size() == 0) begin
                errors++;
                $display("FAIL R2 extra write kind=%0d addr=%0d data=%0d expected none",
                         wr_kind, wr_addr, $signed(wr_data));
            end else begin
                int     ek, ea;
                longint ed;
                string  et;
                ek = q_kind.pop_front();
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                if (int'(wr_kind) != ek || int'(wr_addr) != ea || wr_data != ed[ACC_W-1:0]) begin
                    errors++;
                    $display("FAIL %s actual kind=%0d addr=%0d data=%0d expected kind=%0d addr=%0d data=%0d",
                             et, wr_kind, wr_addr, $signed(wr_data), ek, ea, ed);
                end
            end
        end
    end

    // Burst monitor: each read burst must last exactly n cycles (R4).
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            run_len++;
        end else if (run_len > 0) begin
            checks++;
            if (run_len != cur_n) begin
                errors++;
                $display("FAIL R4 burst length actual=%0d expected=%0d", run_len, cur_n);
            end
            bursts++;
            run_len = 0;
        end
    end

    function automatic int sample(int k, int i, int seed, int amp, int offs);
        return ((k * 131 + i * 71 + seed * 17) % (2 * amp + 1)) - amp + offs;
    endfunction

    task automatic push(int kind, int addr, longint data, string tag);
        q_kind.push_back(kind);
        q_addr.push_back(addr);
        q_data.push_back(data);
        q_tag.push_back(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: fill memory, build the expected write list, run, close out.
    task automatic run_case(int m, int n, int seed, int amp, int offs, string tag, bit poke);
        longint xs [DIM_MAX][CNT_MAX];
        longint mean [DIM_MAX];
        int     idx = 0;
        int     wait_cyc = 0;
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < m; i++) begin
                xs[i][k] = longint'(sample(k, i, seed, amp, offs));
                mem[k * m + i] = DATA_W'(xs[i][k]);
            end
        end
        for (int i = 0; i < m; i++) begin
            longint s = 0;
            for (int k = 0; k < n; k++) s += xs[i][k];
            mean[i] = s / longint'(n);
            push(0, i, mean[i], {"R1 ", tag});
        end
        for (int i = 0; i < m; i++) begin
            for (int j = i; j < m; j++) begin
                longint s = 0;
                if (i == j) begin
                    for (int k = 0; k < n; k++) push(1, k * m + i, xs[i][k] - mean[i], {"R3 ", tag});
                end
                for (int k = 0; k < n; k++) s += (xs[i][k] - mean[i]) * (xs[j][k] - mean[j]);
                push(2, idx, s / longint'(n - 1), {"R2 ", tag});
                idx++;
            end
        end
        cur_n = n;
        bursts = 0;
        @(negedge clk);
        cfg_dims = DIM_W'(m);
        cfg_count = CNT_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            cfg_dims = DIM_W'(1);
            cfg_count = CNT_W'(2);
            start = 1'b1;   // R6: must be ignored mid-run
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && wait_cyc < 30000) begin
            @(negedge clk);
            wait_cyc++;
        end
        checks++;
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog: done actual=0 expected=1 (%s)", tag);
            finish_run();
        end
        checks++;
        if (busy) begin
            errors++;
            $display("FAIL R7 busy at done actual=1 expected=0");
        end
        @(negedge clk);
        checks++;
        if (done) begin
            errors++;
            $display("FAIL R7 done width actual=2+ cycles expected=1");
        end
        checks++;
        if (q_kind.size() != 0) begin
            errors++;
            $display("FAIL R2 missing writes actual=%0d left expected=0 (%s)", q_kind.size(), tag);
            q_kind.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
        end
        checks++;   // R10: division gaps split every result into its own burst
        if (bursts != m + m * (m + 1) / 2) begin
            errors++;
            $display("FAIL R10 bursts actual=%0d expected=%0d", bursts, m + m * (m + 1) / 2);
        end
    endtask

    // Global watchdog.
    initial begin
        #1900000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R8
        if (busy || done || rd_en || wr_valid) begin
            errors++;
            $display("FAIL R8 reset outputs actual=%b%b%b%b expected=0000", busy, done, rd_en, wr_valid);
        end
        rst_n = 1'b1;
        run_case(3, 4, 1, 1000, 0, "small", 1'b0);
        run_case(1, 2, 2, 500, 0, "minimum", 1'b0);
        run_case(4, 5, 3, 3000, -3000, "R9 negative", 1'b0);
        run_case(2, 3, 4, 2000, 100, "R6 start ignored", 1'b1);
        run_case(8, 64, 5, 32767, 0, "maximum", 1'b0);
        finish_run();
    end

endmodule